// File: doc/BRIEF.md
# NAND Page-Read Command Sequencer

This block turns a single read request into the byte-wide command and address cycles that a raw parallel NAND flash device expects before it can stream out a page. The requester gives a block number, a page index inside that block, a column offset and an opcode, and pulses a start strobe. The block computes the row address, lays out the latch cycles in the order required by either the small-page or the large-page device family, and drives the command-latch, address-latch, chip-enable and write-enable pins together with the 8-bit I/O bus.

The block waits for the device's ready/busy line to report ready before the first latch cycle. Once the last cycle has been latched, it deasserts both latch-select lines and keeps chip enable low. It then ignores the ready line for a short window, so that a ready level left over from before the command is not mistaken for completion. After that window it waits for ready once more and ends the request with a one-cycle done pulse. Reading the page data out of the device is left to the logic that follows this block.

Page format, an optional extra row-address cycle and a 16-bit device bus are all chosen by parameters. On large-page devices, a spare-area read is carried out as a normal read whose column offset is moved past the main page.

Top module: `nand_rdcmd_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, ce_n_o and we_n_o are 1 and cle_o, ale_o, busy_o and done_o are 0.
- R2: After start_i is accepted, no write-enable strobe is issued until rdy_i has been seen high through a two-flop synchronizer. busy_o is 1 the whole time the block waits.
- R3: The row address equals pg_i + blk_i * PAGES_PER_BLK. It is sent low byte first: row[7:0], then row[15:8].
- R4: Small-page mode (LARGE_PAGE=0) latches these cycles in order: opcode with cle_o=1, then column[7:0], row[7:0] and row[15:8] with ale_o=1.
- R5: Large-page mode latches these cycles in order: opcode (cle_o=1), column[7:0], column[15:8], row[7:0], row[15:8] (each with ale_o=1), then the confirm opcode 0x30 with cle_o=1.
- R6: With EXTRA_ROW=1, one more ale_o cycle follows row[15:8] and carries {4'h0, row[19:16]}. In large-page mode it comes before the confirm cycle.
- R7: In large-page mode, opcode 0x50 is sent as 0x00 with PAGE_BYTES added to the column. In small-page mode, 0x50 and the column are sent unchanged.
- R8: With BUS16=1, the column, after any R7 adjustment, is shifted right by one bit before it is sent.
- R9: Each latch cycle holds cle_o, ale_o and io_o for one clock before we_n_o falls. we_n_o then stays low for exactly WE_LOW_CLKS clocks, and the values are held for one clock after it rises. cle_o and ale_o are never both 1.
- R10: After the last latch cycle, cle_o and ale_o stay 0 and ce_n_o stays 0 until done. rdy_i is ignored for IGNORE_CLKS clocks, then done waits for a synchronized high on rdy_i.
- R11: A start_i pulse that arrives while busy_o is 1 has no effect: the latched bytes and the number of done pulses are unchanged.
- R12: done_o is a single-cycle pulse. busy_o is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, accepted only when idle |
| blk_i | input | BLK_W | Block number |
| pg_i | input | PG_W | Page index inside the block |
| col_i | input | COL_W | Column byte offset |
| cmd_i | input | 8 | Read opcode (0x00 main area, 0x50 spare area) |
| rdy_i | input | 1 | Device ready/busy line, 1 = ready, asynchronous |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch select |
| ale_o | output | 1 | Address latch select |
| we_n_o | output | 1 | Write enable, active low; bytes latch on its rising edge |
| io_o | output | 8 | Command/address byte |

## Verification
Both address layouts are swept over block numbers up to the largest one, page indices at both ends of the block and columns from zero up to the last byte of a page, using spare-area and main-area opcodes. Each latched byte is compared with a value computed in the bench. Such a sweep catches a wrong row multiply, swapped byte order, a missing or extra cycle, a spare-area translation applied in the wrong mode, and a column halved at the wrong point. Directed cases hold ready low before the request, where a design that skipped the first wait would strobe too early. They also drop ready just after the last strobe, where a design without the ignore window, or without the second wait, would pulse done while the device is still busy. A second start is fired in the middle of a request, where a design that reloaded its inputs would send mixed addresses or give two done pulses. The strobe width and the pin levels after the last cycle are checked on every request.

// File: rtl/nand_seq_pkg.sv
// Shared types and opcodes for the NAND page-read command sequencer.
// Assumes an 8-bit command/address bus; wider data buses still use it.
package nand_seq_pkg;

    // Which latch line a bus cycle raises.
    typedef enum logic [1:0] {
        LAT_IDLE = 2'd0,
        LAT_CMD  = 2'd1,
        LAT_ADDR = 2'd2
    } lat_e;

    // One command or address cycle on the device bus.
    typedef struct packed {
        lat_e       lat;
        logic [7:0] data;
    } bus_cyc_t;

    // Sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WRDY   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_STROBE = 3'd3,
        ST_HOLD   = 3'd4,
        ST_GAP    = 3'd5,
        ST_WDONE  = 3'd6
    } seq_st_e;

    localparam logic [7:0] OP_READ    = 8'h00;
    localparam logic [7:0] OP_SPARE   = 8'h50;
    localparam logic [7:0] OP_CONFIRM = 8'h30;

    // Build a bus cycle from its latch select and byte.
    function automatic bus_cyc_t mk_cyc(input lat_e l, input logic [7:0] d);
        bus_cyc_t c;
        c.lat  = l;
        c.data = d;
        return c;
    endfunction

endpackage

// File: rtl/nand_rdy_sync.sv
// Brings the asynchronous ready/busy line into the clock domain.
// Assumes STAGES >= 2; the output resets to "not ready".
module nand_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] sr_q;

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-2:0], d_i};
    end

    assign q_o = sr_q[STAGES-1];

endmodule

// File: rtl/nand_req_latch.sv
// Captures a read request and converts it into the effective opcode,
// column and row that are sent to the device.
// Assumes PAGES_PER_BLK * 2**BLK_W fits in ROW_W bits and that the
// adjusted column fits in 16 bits.
module nand_req_latch
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE    = 1,
    parameter int BUS16         = 0,
    parameter int PAGE_BYTES    = 2048,
    parameter int PAGES_PER_BLK = 64,
    parameter int BLK_W         = 14,
    parameter int PG_W          = 6,
    parameter int COL_W         = 12,
    parameter int ROW_W         = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BLK_W-1:0]  blk_i,
    input  logic [PG_W-1:0]   pg_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [7:0]        cmd_i,
    output logic [7:0]        cmd_o,
    output logic [15:0]       col_o,
    output logic [ROW_W-1:0]  row_o
);

    logic [7:0]       cmd_x;
    logic [15:0]      col_sp;
    logic [15:0]      col_x;
    logic [ROW_W-1:0] row_x;

    // Spare-area reads on large pages become main reads past the page end.
    always_comb begin
        cmd_x  = cmd_i;
        col_sp = 16'(col_i);
        if (LARGE_PAGE != 0 && cmd_i == OP_SPARE) begin
            cmd_x  = OP_READ;
            col_sp = 16'(col_i) + 16'(PAGE_BYTES);
        end
    end

    // Byte-to-word column conversion chosen by the bus width.
    generate
        if (BUS16 != 0) begin : g_word
            assign col_x = col_sp >> 1;
        end else begin : g_byte
            assign col_x = col_sp;
        end
    endgenerate

    // Row address is the page within the block plus the block's first page.
    assign row_x = ROW_W'(pg_i) + ROW_W'(blk_i) * ROW_W'(PAGES_PER_BLK);

    // Hold the converted request for the duration of the sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o <= '0;
            col_o <= '0;
            row_o <= '0;
        end else if (load_i) begin
            cmd_o <= cmd_x;
            col_o <= col_x;
            row_o <= row_x;
        end
    end

endmodule

// File: rtl/nand_cyc_rom.sv
// Maps a cycle index to the latch select and byte for that cycle,
// for the small-page or large-page layout chosen by parameter.
// Assumes ROW_W >= 20 and an index below the cycle count.
module nand_cyc_rom
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE = 1,
    parameter int EXTRA_ROW  = 0,
    parameter int ROW_W      = 20,
    parameter int IDX_W      = 3
) (
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       cmd_i,
    input  logic [15:0]      col_i,
    input  logic [ROW_W-1:0] row_i,
    output bus_cyc_t         cyc_o
);

    logic [7:0] row_hi;
    assign row_hi = {4'h0, row_i[19:16]};

    generate
        if (LARGE_PAGE != 0) begin : g_large
            // Opcode, two column bytes, two or three row bytes, confirm.
            always_comb begin
                case (int'(idx_i))
                    0: cyc_o = mk_cyc(LAT_CMD,  cmd_i);
                    1: cyc_o = mk_cyc(LAT_ADDR, col_i[7:0]);
                    2: cyc_o = mk_cyc(LAT_ADDR, col_i[15:8]);
                    3: cyc_o = mk_cyc(LAT_ADDR, row_i[7:0]);
                    4: cyc_o = mk_cyc(LAT_ADDR, row_i[15:8]);
                    5: cyc_o = (EXTRA_ROW != 0) ? mk_cyc(LAT_ADDR, row_hi)
                                                : mk_cyc(LAT_CMD, OP_CONFIRM);
                    6: cyc_o = mk_cyc(LAT_CMD,  OP_CONFIRM);
                    default: cyc_o = mk_cyc(LAT_IDLE, 8'h00);
                endcase
            end
        end else begin : g_small
            logic unused_col_hi;
            assign unused_col_hi = ^col_i[15:8];
            // Opcode, one column byte, two or three row bytes.
            always_comb begin
                case (int'(idx_i))
                    0: cyc_o = mk_cyc(LAT_CMD,  cmd_i);
                    1: cyc_o = mk_cyc(LAT_ADDR, col_i[7:0]);
                    2: cyc_o = mk_cyc(LAT_ADDR, row_i[7:0]);
                    3: cyc_o = mk_cyc(LAT_ADDR, row_i[15:8]);
                    4: cyc_o = mk_cyc(LAT_ADDR, row_hi);
                    default: cyc_o = mk_cyc(LAT_IDLE, 8'h00);
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/nand_rdcmd_seq.sv
// Top of the NAND page-read command sequencer. It waits for ready, issues
// every latch cycle with setup / strobe / hold phases, masks the ready line
// for a fixed window, then waits for ready and pulses done.
// Assumes WE_LOW_CLKS >= 1, IGNORE_CLKS >= 1 and rdy_i asynchronous.
module nand_rdcmd_seq
    import nand_seq_pkg::*;
#(
    parameter int LARGE_PAGE    = 1,
    parameter int EXTRA_ROW     = 0,
    parameter int BUS16         = 0,
    parameter int PAGE_BYTES    = 2048,
    parameter int PAGES_PER_BLK = 64,
    parameter int BLK_W         = 14,
    parameter int PG_W          = 6,
    parameter int COL_W         = 12,
    parameter int ROW_W         = 20,
    parameter int WE_LOW_CLKS   = 2,
    parameter int IGNORE_CLKS   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [BLK_W-1:0] blk_i,
    input  logic [PG_W-1:0]  pg_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [7:0]       cmd_i,
    input  logic             rdy_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             ce_n_o,
    output logic             cle_o,
    output logic             ale_o,
    output logic             we_n_o,
    output logic [7:0]       io_o
);

    localparam int NCYC     = (LARGE_PAGE != 0) ? ((EXTRA_ROW != 0) ? 7 : 6)
                                                : ((EXTRA_ROW != 0) ? 5 : 4);
    localparam int IDX_W    = 3;
    localparam int WAIT_MAX = (WE_LOW_CLKS > IGNORE_CLKS) ? WE_LOW_CLKS : IGNORE_CLKS;
    localparam int CNT_W    = $clog2(WAIT_MAX + 1);

    seq_st_e          st_q;
    logic [IDX_W-1:0] idx_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;
    logic             rdy_s;
    logic             load;
    logic             in_cyc;
    logic [7:0]       cmd_q;
    logic [15:0]      col_q;
    logic [ROW_W-1:0] row_q;
    bus_cyc_t         cur;

    nand_rdy_sync #(.STAGES(2)) rdy_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (rdy_i),
        .q_o   (rdy_s)
    );

    assign load = start_i && (st_q == ST_IDLE);

    nand_req_latch #(
        .LARGE_PAGE    (LARGE_PAGE),
        .BUS16         (BUS16),
        .PAGE_BYTES    (PAGE_BYTES),
        .PAGES_PER_BLK (PAGES_PER_BLK),
        .BLK_W         (BLK_W),
        .PG_W          (PG_W),
        .COL_W         (COL_W),
        .ROW_W         (ROW_W)
    ) req_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .blk_i  (blk_i),
        .pg_i   (pg_i),
        .col_i  (col_i),
        .cmd_i  (cmd_i),
        .cmd_o  (cmd_q),
        .col_o  (col_q),
        .row_o  (row_q)
    );

    nand_cyc_rom #(
        .LARGE_PAGE (LARGE_PAGE),
        .EXTRA_ROW  (EXTRA_ROW),
        .ROW_W      (ROW_W),
        .IDX_W      (IDX_W)
    ) rom_i (
        .idx_i (idx_q),
        .cmd_i (cmd_q),
        .col_i (col_q),
        .row_i (row_q),
        .cyc_o (cur)
    );

    // Sequence control: ready wait, per-cycle strobe phases, mask, final wait.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            idx_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: if (start_i) begin
                    st_q  <= ST_WRDY;
                    idx_q <= '0;
                end
                ST_WRDY: if (rdy_s) st_q <= ST_SETUP;
                ST_SETUP: begin
                    st_q  <= ST_STROBE;
                    cnt_q <= CNT_W'(WE_LOW_CLKS - 1);
                end
                ST_STROBE: if (cnt_q == '0) st_q <= ST_HOLD;
                           else             cnt_q <= cnt_q - 1'b1;
                ST_HOLD: if (idx_q == IDX_W'(NCYC - 1)) begin
                    st_q  <= ST_GAP;
                    cnt_q <= CNT_W'(IGNORE_CLKS - 1);
                end else begin
                    idx_q <= idx_q + 1'b1;
                    st_q  <= ST_SETUP;
                end
                ST_GAP: if (cnt_q == '0) st_q <= ST_WDONE;
                        else             cnt_q <= cnt_q - 1'b1;
                ST_WDONE: if (rdy_s) begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // Pin drive from the current state and cycle entry.
    assign in_cyc = (st_q == ST_SETUP) || (st_q == ST_STROBE) || (st_q == ST_HOLD);
    assign cle_o  = in_cyc && (cur.lat == LAT_CMD);
    assign ale_o  = in_cyc && (cur.lat == LAT_ADDR);
    assign io_o   = in_cyc ? cur.data : 8'h00;
    assign we_n_o = (st_q != ST_STROBE);
    assign ce_n_o = (st_q == ST_IDLE);
    assign busy_o = (st_q != ST_IDLE);
    assign done_o = done_q;

    a_r9_latch_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cle_o && ale_o));

    a_r9_bus_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n_o && $past(!we_n_o)) |-> ($stable(io_o) && $stable(cle_o) && $stable(ale_o)));

    a_r10_we_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n_o |-> !ce_n_o);

    a_r2_no_strobe_unready: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WRDY && !rdy_s) |=> we_n_o);

    a_r11_req_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(row_q) && $stable(col_q) && $stable(cmd_q)));

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: tb/nand_rdcmd_seq_tb_top.sv
`timescale 1ns/1ps
// Bench: one large-page 8-bit instance and one small-page 16-bit instance
// with the extra row cycle; latched bytes are captured on each write-enable
// rising edge and compared with values computed here.
module nand_rdcmd_seq_tb_top;

    localparam int BLK_W = 14;
    localparam int PG_W  = 6;
    localparam int COL_W = 12;
    localparam int WE_LOW = 2;
    localparam int IGN    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_l = 1'b0;
    logic start_s = 1'b0;
    logic [BLK_W-1:0] blk = '0;
    logic [PG_W-1:0]  pg  = '0;
    logic [COL_W-1:0] col = '0;
    logic [7:0]       cmd = '0;
    logic rdy = 1'b1;

    logic busy_l, done_l, ce_n_l, cle_l, ale_l, we_n_l;
    logic busy_s, done_s, ce_n_s, cle_s, ale_s, we_n_s;
    logic [7:0] io_l, io_s;

    always #2.5 clk = ~clk;

    nand_rdcmd_seq #(
        .LARGE_PAGE(1), .EXTRA_ROW(0), .BUS16(0), .PAGE_BYTES(2048),
        .PAGES_PER_BLK(64), .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W),
        .ROW_W(20), .WE_LOW_CLKS(WE_LOW), .IGNORE_CLKS(IGN)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_l), .blk_i(blk), .pg_i(pg),
        .col_i(col), .cmd_i(cmd), .rdy_i(rdy), .busy_o(busy_l), .done_o(done_l),
        .ce_n_o(ce_n_l), .cle_o(cle_l), .ale_o(ale_l), .we_n_o(we_n_l), .io_o(io_l)
    );

    nand_rdcmd_seq #(
        .LARGE_PAGE(0), .EXTRA_ROW(1), .BUS16(1), .PAGE_BYTES(512),
        .PAGES_PER_BLK(32), .BLK_W(BLK_W), .PG_W(PG_W), .COL_W(COL_W),
        .ROW_W(20), .WE_LOW_CLKS(WE_LOW), .IGNORE_CLKS(IGN)
    ) dut_s_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_s), .blk_i(blk), .pg_i(pg),
        .col_i(col), .cmd_i(cmd), .rdy_i(rdy), .busy_o(busy_s), .done_o(done_s),
        .ce_n_o(ce_n_s), .cle_o(cle_s), .ale_o(ale_s), .we_n_o(we_n_s), .io_o(io_s)
    );

    logic [1:0] we_v, cle_v, ale_v, ce_v, busy_v, done_v;
    logic [7:0] io_v [2];
    assign we_v   = {we_n_s, we_n_l};
    assign cle_v  = {cle_s, cle_l};
    assign ale_v  = {ale_s, ale_l};
    assign ce_v   = {ce_n_s, ce_n_l};
    assign busy_v = {busy_s, busy_l};
    assign done_v = {done_s, done_l};
    assign io_v[0] = io_l;
    assign io_v[1] = io_s;

    logic [9:0] cap  [2][16];
    logic [9:0] expv [2][16];
    int ncap[2], nfall[2], ndone[2], done_cyc[2], last_cap_cyc[2];
    int we_low_run[2], bad_width[2], post_bad[2], exp_n[2];
    logic prev_we[2];
    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Observe both instances between clock edges.
    always @(negedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (rst_n) begin
                if (prev_we[u] && !we_v[u]) begin
                    nfall[u]++;
                    we_low_run[u] = 0;
                end
                if (!we_v[u]) we_low_run[u]++;
                if (!prev_we[u] && we_v[u]) begin
                    if (we_low_run[u] != WE_LOW) bad_width[u]++;
                    if (ncap[u] < 16) cap[u][ncap[u]] = {cle_v[u], ale_v[u], io_v[u]};
                    ncap[u]++;
                    last_cap_cyc[u] = cyc;
                end else if (busy_v[u] && exp_n[u] > 0 && ncap[u] >= exp_n[u]
                             && (cle_v[u] || ale_v[u])) begin
                    post_bad[u]++;
                end
                if (busy_v[u] && ce_v[u]) post_bad[u]++;
                if (done_v[u]) begin
                    ndone[u]++;
                    done_cyc[u] = cyc;
                end
            end
            prev_we[u] = we_v[u];
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int u, input logic [1:0] l, input int b);
        expv[u][exp_n[u]] = {l, 8'(b & 255)};
        exp_n[u]++;
    endtask

    // Expected latch cycles for unit u (0 = large 8-bit, 1 = small 16-bit extra row).
    task automatic build_exp(input int u, input int b, input int p, input int c, input int k);
        int ppb, pb, row, cc, kk;
        ppb = (u == 0) ? 64 : 32;
        pb  = (u == 0) ? 2048 : 512;
        row = p + b * ppb;
        cc  = c;
        kk  = k;
        if (u == 0 && k == 'h50) begin kk = 0; cc = cc + pb; end
        if (u == 1) cc = cc >> 1;
        exp_n[u] = 0;
        push(u, 2'b10, kk);
        push(u, 2'b01, cc);
        if (u == 0) push(u, 2'b01, cc >> 8);
        push(u, 2'b01, row);
        push(u, 2'b01, row >> 8);
        if (u == 1) push(u, 2'b01, (row >> 16) & 15);
        if (u == 0) push(u, 2'b10, 'h30);
    endtask

    task automatic run_start(input int u, input int b, input int p, input int c, input int k);
        build_exp(u, b, p, c, k);
        ncap[u] = 0; nfall[u] = 0; ndone[u] = 0; bad_width[u] = 0;
        post_bad[u] = 0; done_cyc[u] = -1;
        @(negedge clk);
        blk = BLK_W'(b); pg = PG_W'(p); col = COL_W'(c); cmd = 8'(k);
        if (u == 0) start_l = 1'b1; else start_s = 1'b1;
        @(negedge clk);
        start_l = 1'b0; start_s = 1'b0;
    endtask

    task automatic run_finish(input int u);
        string tag;
        int t;
        tag = (u == 0) ? "R5" : "R4";
        t = 0;
        while (ndone[u] == 0 && t < 400) begin @(posedge clk); t++; end
        @(posedge clk); @(posedge clk);
        check(ncap[u] == exp_n[u], tag, "cycle count", ncap[u], exp_n[u]);
        for (int i = 0; i < exp_n[u] && i < 16; i++)
            check(cap[u][i] == expv[u][i], tag, $sformatf("latched cycle %0d", i),
                  cap[u][i], expv[u][i]);
        check(ndone[u] == 1, "R12", "done pulse cycles", ndone[u], 1);
        check(busy_v[u] == 1'b0, "R12", "busy after done", busy_v[u], 0);
        check(bad_width[u] == 0, "R9", "strobe width errors", bad_width[u], 0);
        check(post_bad[u] == 0, "R10", "latch/ce level after last cycle", post_bad[u], 0);
        check(done_cyc[u] - last_cap_cyc[u] >= IGN + 1, "R10", "ready mask window",
              done_cyc[u] - last_cap_cyc[u], IGN + 1);
    endtask

    task automatic run_one(input int u, input int b, input int p, input int c, input int k);
        run_start(u, b, p, c, k);
        run_finish(u);
    endtask

    initial begin
        int blks_l[4] = '{0, 1, 777, 16383};
        int pgs_l[3]  = '{0, 1, 63};
        int cols_l[3] = '{0, 5, 2047};
        int blks_s[3] = '{0, 1, 16383};
        int pgs_s[2]  = '{0, 31};
        int cols_s[3] = '{0, 255, 511};
        int cmds[2]   = '{'h00, 'h50};
        int rise_cyc;
        int t;

        for (int u = 0; u < 2; u++) begin
            ncap[u] = 0; nfall[u] = 0; ndone[u] = 0; exp_n[u] = 0;
            bad_width[u] = 0; post_bad[u] = 0; prev_we[u] = 1'b1; we_low_run[u] = 0;
        end

        // R1: pin state during and right after reset.
        repeat (4) @(negedge clk);
        for (int u = 0; u < 2; u++)
            check({ce_v[u], we_v[u], cle_v[u], ale_v[u], busy_v[u], done_v[u]} == 6'b110000,
                  "R1", "pins in reset",
                  {ce_v[u], we_v[u], cle_v[u], ale_v[u], busy_v[u], done_v[u]}, 6'b110000);
        rst_n = 1'b1;
        @(negedge clk);
        for (int u = 0; u < 2; u++)
            check({ce_v[u], we_v[u], cle_v[u], ale_v[u], busy_v[u], done_v[u]} == 6'b110000,
                  "R1", "pins after reset",
                  {ce_v[u], we_v[u], cle_v[u], ale_v[u], busy_v[u], done_v[u]}, 6'b110000);

        // R2: no strobe while the device reports busy.
        rdy = 1'b0;
        run_start(0, 2, 3, 4, 'h00);
        repeat (20) @(posedge clk);
        check(nfall[0] == 0, "R2", "strobes while not ready", nfall[0], 0);
        check(busy_l == 1'b1, "R2", "busy while waiting", busy_l, 1);
        @(negedge clk);
        rdy = 1'b1;
        run_finish(0);

        // R3: row address arithmetic.
        run_one(0, 3, 5, 0, 'h00);
        check(cap[0][3] == {2'b01, 8'd197}, "R3", "row low byte", cap[0][3], {2'b01, 8'd197});
        check(cap[0][4] == {2'b01, 8'd0}, "R3", "row mid byte", cap[0][4], {2'b01, 8'd0});
        run_one(0, 16383, 63, 0, 'h00);
        check(cap[0][4] == {2'b01, 8'hFF}, "R3", "row mid byte max", cap[0][4], {2'b01, 8'hFF});

        // R5: confirm opcode closes the large-page sequence.
        check(cap[0][5] == {2'b10, 8'h30}, "R5", "confirm cycle", cap[0][5], {2'b10, 8'h30});

        // R7: spare-area read translated on large pages.
        run_one(0, 0, 0, 7, 'h50);
        check(cap[0][0] == {2'b10, 8'h00}, "R7", "spare opcode", cap[0][0], {2'b10, 8'h00});
        check(cap[0][2] == {2'b01, 8'h08}, "R7", "spare column high", cap[0][2], {2'b01, 8'h08});

        // R7 and R8: small page keeps 0x50; 16-bit halves the column.
        run_one(1, 0, 0, 'h1FE, 'h50);
        check(cap[1][0] == {2'b10, 8'h50}, "R7", "small opcode kept", cap[1][0], {2'b10, 8'h50});
        check(cap[1][1] == {2'b01, 8'hFF}, "R8", "word column", cap[1][1], {2'b01, 8'hFF});

        // R6: extra row cycle carries row[19:16] with a zero upper nibble.
        run_one(1, 16383, 31, 0, 'h00);
        check(cap[1][4] == {2'b01, 8'h07}, "R6", "extra row cycle", cap[1][4], {2'b01, 8'h07});

        // R10: ready drops just after the last strobe; done must wait for it.
        run_start(0, 9, 9, 9, 'h00);
        t = 0;
        while (ncap[0] < exp_n[0] && t < 400) begin @(posedge clk); t++; end
        @(negedge clk);
        rdy = 1'b0;
        repeat (15) @(negedge clk);
        check(ndone[0] == 0, "R10", "done while device busy", ndone[0], 0);
        rise_cyc = cyc;
        rdy = 1'b1;
        run_finish(0);
        check(done_cyc[0] - rise_cyc >= 2 && done_cyc[0] - rise_cyc <= 5, "R10",
              "done after ready return", done_cyc[0] - rise_cyc, 3);

        // R11: a second start in mid-sequence is ignored.
        run_start(0, 100, 10, 20, 'h00);
        repeat (5) @(negedge clk);
        blk = 14'd5; pg = 6'd1; col = 12'd1; cmd = 8'h50;
        start_l = 1'b1;
        @(negedge clk);
        start_l = 1'b0;
        run_finish(0);
        check(cap[0][3] == {2'b01, 8'(100 * 64 + 10)}, "R11", "row kept",
              cap[0][3], {2'b01, 8'(100 * 64 + 10)});

        // Sweeps over both layouts (R3, R4, R5, R7, R8, R9, R10, R12).
        foreach (cmds[k]) foreach (blks_l[b]) foreach (pgs_l[p]) foreach (cols_l[c])
            run_one(0, blks_l[b], pgs_l[p], cols_l[c], cmds[k]);
        foreach (cmds[k]) foreach (blks_s[b]) foreach (pgs_s[p]) foreach (cols_s[c])
            run_one(1, blks_s[b], pgs_s[p], cols_s[c], cmds[k]);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #600000;
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule